// File: doc/BRIEF.md
# Security and Sector Protection Controller

This block keeps the write-protect state for two non-volatile memories: a primary memory of eight sectors and a secondary memory of four. It also keeps a security lock. Every program or erase request bound for a sector passes through the block, which answers one cycle later with either a grant or an error. The memory arrays are not part of the block and appear only as the request, grant and error signals.

Two ports reach the stored state. The privileged programming port is the serial test path or an external programmer. It can load either protection vector, set the lock, and start a full-chip erase. The MCU register port can load and read the protection vectors. It can never change the lock. While the lock is set, every MCU read returns zeros.

A full-chip erase is the only way to clear the lock. It also clears every protection bit in the same cycle. All stored bits come out of reset at 0, which is the unprogrammed state of the configuration.

Top module: `secprot_ctrl`

## Requirements
- R1: After reset the lock, all protection bits, `lock_out`, `erase_done`, `req_grant`, `req_error` and `mcu_rdata` are 0.
- R2: A privileged write with select 2 and `prg_wdata[0]`=1 sets the lock on the next edge. A privileged write of 0 to select 2 leaves a set lock unchanged.
- R3: MCU writes never change the lock, including a write to address 2.
- R4: A privileged write with select 0 loads the 8 primary protection bits from `prg_wdata`. Select 1 loads the 4 secondary bits from `prg_wdata[3:0]`. Bit n protects sector n.
- R5: An MCU write to address 0 or address 1 loads the primary or secondary protection bits in the same way as R4. This works whether or not the lock is set.
- R6: An MCU read returns data one cycle later. Address 0 gives the primary bits, address 1 gives {4'b0, secondary bits}, address 2 gives {7'b0, lock} and address 3 gives 0. While the lock is set, every read returns 0.
- R7: One cycle after a request, the block raises `req_grant` if the sector is unprotected. It raises `req_error` instead if the sector is protected, or if the bank is the secondary memory (`req_bank`=1) and `req_sector` is 4 or more. Each flag lasts one cycle.
- R8: `prg_chip_erase` clears the lock and all protection bits on the next edge and pulses `erase_done` for one cycle.
- R9: A chip erase overrides any write in the same cycle. If a privileged write and an MCU write hit the same register in the same cycle, the privileged write wins.
- R10: A request is judged against the protection bits held before the edge. A write in the same cycle does not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prg_wr_en | input | 1 | Privileged write strobe |
| prg_sel | input | 2 | Privileged target: 0 primary, 1 secondary, 2 lock, 3 none |
| prg_wdata | input | 8 | Privileged write data |
| prg_chip_erase | input | 1 | Full-chip erase strobe |
| mcu_wr_en | input | 1 | MCU write strobe |
| mcu_rd_en | input | 1 | MCU read strobe |
| mcu_addr | input | 2 | MCU register address, same encoding as prg_sel |
| mcu_wdata | input | 8 | MCU write data |
| mcu_rdata | output | 8 | MCU read data, valid one cycle after the read |
| req_valid | input | 1 | Program/erase request |
| req_bank | input | 1 | 0 primary memory, 1 secondary memory |
| req_sector | input | 3 | Target sector index |
| req_grant | output | 1 | Request allowed (one-cycle pulse) |
| req_error | output | 1 | Request rejected (one-cycle pulse) |
| lock_out | output | 1 | Security lock state |
| erase_done | output | 1 | Full-chip erase completed (one-cycle pulse) |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a register update and a sector request. The bench sends a request in the same cycle that a privileged write lifts the protection on that sector. The request must still be rejected under the old bits, and a later request must be granted.

The second pair is the chip erase and a write. The bench issues an erase together with a privileged write and an MCU write. It then checks that the lock and both protection vectors read back as zero. The same-cycle privileged-versus-MCU write is judged by a follow-up request to a sector whose protection only the privileged data would set.

// File: rtl/secprot_pkg.sv
// Package: shared encodings for the protection controller.
// Assumes both ports use the same 2-bit register select encoding.
package secprot_pkg;
    typedef enum logic [1:0] {
        SEL_PRI  = 2'd0,
        SEL_SEC  = 2'd1,
        SEL_LOCK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/secprot_regs.sv
// Module: holds the lock bit and both protection vectors.
// Priority per register: chip erase, then privileged write, then MCU write.
// The lock can only be set by the privileged port and cleared by erase.
// Assumes SEC_N <= PRI_N.
module secprot_regs #(
    parameter int PRI_N = 8,
    parameter int SEC_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prg_wr_en,
    input  logic [1:0]       prg_sel,
    input  logic [PRI_N-1:0] prg_wdata,
    input  logic             prg_chip_erase,
    input  logic             mcu_wr_en,
    input  logic [1:0]       mcu_addr,
    input  logic [PRI_N-1:0] mcu_wdata,
    output logic             lock_q,
    output logic [PRI_N-1:0] pri_prot_q,
    output logic [SEC_N-1:0] sec_prot_q,
    output logic             erase_done_q
);
    import secprot_pkg::*;

    reg_sel_e prg_t, mcu_t;
    logic prg_pri, prg_sec, prg_lock, mcu_pri, mcu_sec;

    // Decode the write targets of both ports.
    always_comb begin
        prg_t    = reg_sel_e'(prg_sel);
        mcu_t    = reg_sel_e'(mcu_addr);
        prg_pri  = prg_wr_en && (prg_t == SEL_PRI);
        prg_sec  = prg_wr_en && (prg_t == SEL_SEC);
        prg_lock = prg_wr_en && (prg_t == SEL_LOCK) && prg_wdata[0];
        mcu_pri  = mcu_wr_en && (mcu_t == SEL_PRI);
        mcu_sec  = mcu_wr_en && (mcu_t == SEL_SEC);
    end

    // Lock: set only from the privileged port, cleared only by erase.
    always_ff @(posedge clk) begin
        if (!rst_n)              lock_q <= 1'b0;
        else if (prg_chip_erase) lock_q <= 1'b0;
        else if (prg_lock)       lock_q <= 1'b1;
    end

    // Primary protection vector with erase and port priority.
    always_ff @(posedge clk) begin
        if (!rst_n)              pri_prot_q <= '0;
        else if (prg_chip_erase) pri_prot_q <= '0;
        else if (prg_pri)        pri_prot_q <= prg_wdata;
        else if (mcu_pri)        pri_prot_q <= mcu_wdata;
    end

    // Secondary protection vector with erase and port priority.
    always_ff @(posedge clk) begin
        if (!rst_n)              sec_prot_q <= '0;
        else if (prg_chip_erase) sec_prot_q <= '0;
        else if (prg_sec)        sec_prot_q <= prg_wdata[SEC_N-1:0];
        else if (mcu_sec)        sec_prot_q <= mcu_wdata[SEC_N-1:0];
    end

    // Erase completion pulse, one cycle after the erase strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) erase_done_q <= 1'b0;
        else        erase_done_q <= prg_chip_erase;
    end

    // R2
    lock_clear_only_by_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(prg_chip_erase));

    // R3
    lock_set_only_by_prg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(prg_wr_en && prg_sel == 2'd2));

    // R8
    erase_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_chip_erase |=> (!lock_q && pri_prot_q == '0 && sec_prot_q == '0));
endmodule

// File: rtl/secprot_gate.sv
// Module: judges each program/erase request against the protection bits
// held before the edge and returns a one-cycle grant or error.
// Assumes PRI_N is a power of two, so every primary index is in range.
module secprot_gate #(
    parameter int PRI_N = 8,
    parameter int SEC_N = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_bank,
    input  logic [$clog2(PRI_N)-1:0] req_sector,
    input  logic [PRI_N-1:0]         pri_prot_q,
    input  logic [SEC_N-1:0]         sec_prot_q,
    output logic                     grant_q,
    output logic                     error_q
);
    localparam int SW = $clog2(PRI_N);
    localparam int QW = (SEC_N > 1) ? $clog2(SEC_N) : 1;
    localparam logic [SW-1:0] SEC_LIM = SW'(SEC_N);

    logic [SEC_N-1:0] sec_ok_vec;
    logic             allowed;

    // One lane per secondary sector: open when unprotected.
    for (genvar g = 0; g < SEC_N; g++) begin : g_sec_lane
        assign sec_ok_vec[g] = !sec_prot_q[g];
    end

    // Decide whether the current request may proceed.
    always_comb begin
        if (!req_bank)
            allowed = !pri_prot_q[req_sector];
        else if (req_sector < SEC_LIM)
            allowed = sec_ok_vec[req_sector[QW-1:0]];
        else
            allowed = 1'b0;
    end

    // Register the verdict as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            error_q <= 1'b0;
        end else begin
            grant_q <= req_valid && allowed;
            error_q <= req_valid && !allowed;
        end
    end

    // R7
    grant_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_q && error_q));

    // R7
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant_q && !error_q));

    // R10
    pri_protected_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_bank && pri_prot_q[req_sector]) |=> error_q);
endmodule

// File: rtl/secprot_rdport.sv
// Module: registered MCU read mux; returns zeros while locked.
// Assumes the read data width equals PRI_N.
module secprot_rdport #(
    parameter int PRI_N = 8,
    parameter int SEC_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcu_rd_en,
    input  logic [1:0]       mcu_addr,
    input  logic             lock_q,
    input  logic [PRI_N-1:0] pri_prot_q,
    input  logic [SEC_N-1:0] sec_prot_q,
    output logic [PRI_N-1:0] rdata_q
);
    import secprot_pkg::*;

    logic [PRI_N-1:0] mux_d;

    // Select the addressed register, masked by the lock.
    always_comb begin
        mux_d = '0;
        if (!lock_q) begin
            case (reg_sel_e'(mcu_addr))
                SEL_PRI:  mux_d = pri_prot_q;
                SEL_SEC:  mux_d = {{(PRI_N-SEC_N){1'b0}}, sec_prot_q};
                SEL_LOCK: mux_d = {{(PRI_N-1){1'b0}}, lock_q};
                default:  mux_d = '0;
            endcase
        end
    end

    // Capture read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (mcu_rd_en) rdata_q <= mux_d;
    end

    // R6
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_rd_en && lock_q) |=> (rdata_q == '0));
endmodule

// File: rtl/secprot_ctrl.sv
// Module: top of the security and sector protection controller.
// Connects the register file, request gate and MCU read port.
// Assumes PRI_N is a power of two and SEC_N <= PRI_N.
module secprot_ctrl #(
    parameter int PRI_N = 8,
    parameter int SEC_N = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prg_wr_en,
    input  logic [1:0]               prg_sel,
    input  logic [PRI_N-1:0]         prg_wdata,
    input  logic                     prg_chip_erase,
    input  logic                     mcu_wr_en,
    input  logic                     mcu_rd_en,
    input  logic [1:0]               mcu_addr,
    input  logic [PRI_N-1:0]         mcu_wdata,
    output logic [PRI_N-1:0]         mcu_rdata,
    input  logic                     req_valid,
    input  logic                     req_bank,
    input  logic [$clog2(PRI_N)-1:0] req_sector,
    output logic                     req_grant,
    output logic                     req_error,
    output logic                     lock_out,
    output logic                     erase_done
);
    logic             lock_q;
    logic [PRI_N-1:0] pri_prot_q;
    logic [SEC_N-1:0] sec_prot_q;

    secprot_regs #(.PRI_N(PRI_N), .SEC_N(SEC_N)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .prg_wr_en(prg_wr_en), .prg_sel(prg_sel), .prg_wdata(prg_wdata),
        .prg_chip_erase(prg_chip_erase),
        .mcu_wr_en(mcu_wr_en), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
        .lock_q(lock_q), .pri_prot_q(pri_prot_q), .sec_prot_q(sec_prot_q),
        .erase_done_q(erase_done)
    );

    secprot_gate #(.PRI_N(PRI_N), .SEC_N(SEC_N)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_bank(req_bank), .req_sector(req_sector),
        .pri_prot_q(pri_prot_q), .sec_prot_q(sec_prot_q),
        .grant_q(req_grant), .error_q(req_error)
    );

    secprot_rdport #(.PRI_N(PRI_N), .SEC_N(SEC_N)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .mcu_rd_en(mcu_rd_en), .mcu_addr(mcu_addr),
        .lock_q(lock_q), .pri_prot_q(pri_prot_q), .sec_prot_q(sec_prot_q),
        .rdata_q(mcu_rdata)
    );

    assign lock_out = lock_q;

    // R8
    erase_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> ($past(prg_chip_erase) && !lock_out));
endmodule

// File: tb/secprot_ctrl_bench.sv
module secprot_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prg_wr_en = 0, prg_chip_erase = 0, mcu_wr_en = 0, mcu_rd_en = 0;
    logic [1:0] prg_sel = 0, mcu_addr = 0;
    logic [7:0] prg_wdata = 0, mcu_wdata = 0, mcu_rdata;
    logic       req_valid = 0, req_bank = 0;
    logic [2:0] req_sector = 0;
    logic       req_grant, req_error, lock_out, erase_done;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    secprot_ctrl u_secprot_ctrl (
        .clk(clk), .rst_n(rst_n),
        .prg_wr_en(prg_wr_en), .prg_sel(prg_sel), .prg_wdata(prg_wdata),
        .prg_chip_erase(prg_chip_erase),
        .mcu_wr_en(mcu_wr_en), .mcu_rd_en(mcu_rd_en), .mcu_addr(mcu_addr),
        .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
        .req_valid(req_valid), .req_bank(req_bank), .req_sector(req_sector),
        .req_grant(req_grant), .req_error(req_error),
        .lock_out(lock_out), .erase_done(erase_done)
    );

    // Request table: {bank, sector[2:0], exp_grant, exp_error}
    // with primary bits 8'hA5 and secondary bits 4'b0110.
    localparam logic [5:0] REQ_VEC [11] = '{
        {1'b0, 3'd0, 2'b01}, {1'b0, 3'd1, 2'b10}, {1'b0, 3'd2, 2'b01},
        {1'b0, 3'd3, 2'b10}, {1'b0, 3'd4, 2'b10}, {1'b0, 3'd5, 2'b01},
        {1'b0, 3'd7, 2'b01}, {1'b1, 3'd0, 2'b10}, {1'b1, 3'd1, 2'b01},
        {1'b1, 3'd3, 2'b10}, {1'b1, 3'd5, 2'b01}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        prg_wr_en = 0; prg_chip_erase = 0; mcu_wr_en = 0; mcu_rd_en = 0;
        req_valid = 0; prg_sel = 2'd3; mcu_addr = 2'd3;
    endtask

    // Advance past the edge that captures the driven inputs.
    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic prg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); clear_inputs();
        prg_wr_en = 1; prg_sel = sel; prg_wdata = d;
        edge_settle();
    endtask

    task automatic mcu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); clear_inputs();
        mcu_wr_en = 1; mcu_addr = a; mcu_wdata = d;
        edge_settle();
    endtask

    task automatic mcu_read(input logic [1:0] a);
        @(negedge clk); clear_inputs();
        mcu_rd_en = 1; mcu_addr = a;
        edge_settle();
    endtask

    task automatic request(input logic b, input logic [2:0] s);
        @(negedge clk); clear_inputs();
        req_valid = 1; req_bank = b; req_sector = s;
        edge_settle();
    endtask

    task automatic idle();
        @(negedge clk); clear_inputs();
        edge_settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 lock", lock_out, 0);
        check("R1 erase_done", erase_done, 0);
        check("R1 grant", req_grant, 0);
        check("R1 error", req_error, 0);
        check("R1 rdata", mcu_rdata, 0);
        mcu_read(2'd0); check("R1 pri", mcu_rdata, 0);
        mcu_read(2'd1); check("R1 sec", mcu_rdata, 0);
        mcu_read(2'd2); check("R1 lockreg", mcu_rdata, 0);

        // R4 privileged primary load, R5 MCU secondary load
        prg_write(2'd0, 8'hA5);
        mcu_write(2'd1, 8'hF6);
        mcu_read(2'd0); check("R4 pri readback", mcu_rdata, 8'hA5);
        mcu_read(2'd1); check("R5 sec readback", mcu_rdata, 8'h06);
        mcu_read(2'd3); check("R6 addr3 zero", mcu_rdata, 0);
        prg_write(2'd1, 8'h09);
        mcu_read(2'd1); check("R4 sec prg load", mcu_rdata, 8'h09);
        mcu_write(2'd1, 8'h06);

        // R7 request table
        foreach (REQ_VEC[i]) begin
            request(REQ_VEC[i][5], REQ_VEC[i][4:2]);
            check($sformatf("R7 grant vec%0d", i), req_grant, REQ_VEC[i][1]);
            check($sformatf("R7 error vec%0d", i), req_error, REQ_VEC[i][0]);
        end
        idle();
        check("R7 error single cycle", req_error, 0);

        // R3 MCU write to the lock address is ignored
        mcu_write(2'd2, 8'hFF);
        check("R3 lock_out", lock_out, 0);
        mcu_read(2'd2); check("R3 lock readback", mcu_rdata, 0);

        // R2 set lock, then try clearing by write
        prg_write(2'd2, 8'h01);
        check("R2 lock set", lock_out, 1);
        prg_write(2'd2, 8'h00);
        check("R2 lock stays", lock_out, 1);

        // R6 locked reads return zero
        mcu_read(2'd0); check("R6 locked pri", mcu_rdata, 0);
        mcu_read(2'd2); check("R6 locked lockreg", mcu_rdata, 0);

        // R5 MCU write still works while locked
        mcu_write(2'd0, 8'h00);
        request(1'b0, 3'd0);
        check("R5 locked mcu write grant", req_grant, 1);

        // R9 privileged beats MCU on same register
        @(negedge clk); clear_inputs();
        prg_wr_en = 1; prg_sel = 2'd0; prg_wdata = 8'hFF;
        mcu_wr_en = 1; mcu_addr = 2'd0; mcu_wdata = 8'h00;
        edge_settle();
        request(1'b0, 3'd1);
        check("R9 prg priority error", req_error, 1);

        // R10 request in same cycle as unprotect uses old bits
        @(negedge clk); clear_inputs();
        prg_wr_en = 1; prg_sel = 2'd0; prg_wdata = 8'h00;
        req_valid = 1; req_bank = 1'b0; req_sector = 3'd3;
        edge_settle();
        check("R10 old bits error", req_error, 1);
        check("R10 old bits grant", req_grant, 0);
        request(1'b0, 3'd3);
        check("R10 new bits grant", req_grant, 1);

        // R8/R9 erase together with writes
        @(negedge clk); clear_inputs();
        prg_chip_erase = 1;
        prg_wr_en = 1; prg_sel = 2'd0; prg_wdata = 8'hFF;
        mcu_wr_en = 1; mcu_addr = 2'd1; mcu_wdata = 8'h0F;
        edge_settle();
        check("R8 erase_done", erase_done, 1);
        check("R8 lock cleared", lock_out, 0);
        idle();
        check("R8 erase_done single", erase_done, 0);
        mcu_read(2'd0); check("R9 pri after erase", mcu_rdata, 0);
        mcu_read(2'd1); check("R9 sec after erase", mcu_rdata, 0);
        request(1'b1, 3'd2);
        check("R8 sector open after erase", req_grant, 1);

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule